// File: doc/BRIEF.md
# Scroll Address Register with Increment/Reload Conflicts

This block keeps the scroll and memory address state of a tile-based video controller. It holds a 15-bit current address `vaddr`, a 15-bit temporary address `taddr`, a 3-bit fine horizontal offset and a two-phase write toggle. It also follows the dot and scanline counters to apply the increments and reloads that rendering performs.

The bit layout is the same for both addresses: fine Y in [14:12], nametable select in [11:10], coarse Y in [9:5] and coarse X in [4:0]. Register writes from the control, scroll and address ports land in `taddr`. Data-port access pulses step `vaddr`. An increment of `vaddr` and a reload of `vaddr` can fall in the same cycle. When they do, the register keeps the bitwise AND of the two candidates, which matches the bus conflict in the circuit being modelled. An optional input models a control write whose stale early bus value ($20) is seen by the dot-257 reload.

Top module: `scroll_addr_unit`

## Requirements
- R1: After reset, `vaddr`, `taddr`, `fine_x` and `wtog` are all zero.
- R2: A scroll write with toggle 0 sets taddr[4:0]=data[7:3] and fine_x=data[2:0] and sets the toggle. A scroll write with toggle 1 sets taddr[14:12]=data[2:0] and taddr[9:5]=data[7:3] and clears the toggle.
- R3: An address write with toggle 0 sets taddr[13:8]=data[5:0] and clears taddr[14]. An address write with toggle 1 sets taddr[7:0]=data and loads the resulting taddr into vaddr on the same edge.
- R4: A status read clears the write toggle.
- R5: A control write sets taddr[11:10]=data[1:0]. Data bit 2 selects a step of 32 instead of 1 for data-port accesses made outside rendering.
- R6: Outside rendering, a data access adds the selected step to the whole 15-bit vaddr, with carries crossing field boundaries.
- R7: While rendering, coarse X increments at dots 8,16,…,256, 328 and 336. Coarse X 31 wraps to 0 and flips vaddr[10]. Other dots leave coarse X alone.
- R8: At dot 256 of a rendering line, fine Y increments. On fine Y overflow, coarse Y increments. Coarse Y 29 wraps to 0 and flips vaddr[11]. Coarse Y 31 wraps to 0 with no flip.
- R9: At dot 257 of a rendering line, vaddr[4:0] and vaddr[10] are copied from taddr.
- R10: On the prerender line (261), dots 280 to 304 copy vaddr[14:11] and vaddr[9:5] from taddr.
- R11: A data access during rendering applies both the coarse X and the Y increment. When any increment and any reload (dot reload or second address write) happen in the same cycle, vaddr becomes the bitwise AND of the incremented and the reloaded values.
- R12: A control write at dot 257 with `early_ctrl` high makes that reload take vaddr[10] from bit 0 of the early value $20 (that is, 0). taddr still receives the written data.
- R13: Rendering events happen only on lines 0-239 and 261, and only with `render_en` high. Otherwise the dot counter has no effect on vaddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per dot |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Rendering enabled |
| line | input | 9 | Current scanline number |
| dot | input | 9 | Current dot within the scanline |
| wr_ctrl | input | 1 | Control register write strobe |
| wr_scroll | input | 1 | Scroll register write strobe |
| wr_addr | input | 1 | Address register write strobe |
| rd_status | input | 1 | Status register read strobe |
| wdata | input | 8 | Write data for the register strobes |
| data_acc | input | 1 | Data-port read or write pulse |
| early_ctrl | input | 1 | A control write at this dot exposes the stale early value |
| vaddr | output | 15 | Current address |
| taddr | output | 15 | Temporary address |
| fine_x | output | 3 | Fine horizontal scroll |
| wtog | output | 1 | Write toggle |

## Verification
Every result appears on the first clock edge after the cycle that carries the stimulus. This covers register writes into `taddr`, `fine_x` and the toggle, the copy into `vaddr`, and dot increments, reloads and their AND conflicts. The bench drives each stimulus for one cycle starting at a falling edge. It reads the outputs one time unit after the next rising edge, so every check falls exactly in that edge's cycle. For checks that something is ignored, the bench drives a quiet cycle and compares the outputs with their earlier values.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int ADDR_W = 15;
  typedef logic [ADDR_W-1:0] saddr_t;

  // coarse X step: wraps 31 -> 0 and flips horizontal nametable bit
  function automatic saddr_t step_cx(input saddr_t a);
    saddr_t r;
    r = a;
    if (a[4:0] == 5'd31) begin
      r[4:0] = 5'd0;
      r[10]  = ~a[10];
    end else begin
      r[4:0] = a[4:0] + 5'd1;
    end
    return r;
  endfunction

  // vertical step: fine Y, then coarse Y with 29/31 wrap rules
  function automatic saddr_t step_y(input saddr_t a);
    saddr_t r;
    r = a;
    if (a[14:12] != 3'd7) begin
      r[14:12] = a[14:12] + 3'd1;
    end else begin
      r[14:12] = 3'd0;
      if (a[9:5] == 5'd29) begin
        r[9:5] = 5'd0;
        r[11]  = ~a[11];
      end else if (a[9:5] == 5'd31) begin
        r[9:5] = 5'd0;
      end else begin
        r[9:5] = a[9:5] + 5'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/scroll_tregs.sv
module scroll_tregs
  import scroll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_scroll,
  input  logic       wr_addr,
  input  logic       rd_status,
  input  logic [7:0] wdata,
  output saddr_t     t_q,
  output saddr_t     t_nx,
  output logic [2:0] fx_q,
  output logic       tog_q,
  output logic       step32_q,
  output logic       addr_copy
);
  logic [2:0] fx_nx;
  logic       tog_nx;
  logic       step32_nx;

  always_comb begin
    t_nx      = t_q;
    fx_nx     = fx_q;
    tog_nx    = tog_q;
    step32_nx = step32_q;
    if (wr_ctrl) begin
      t_nx[11:10] = wdata[1:0];
      step32_nx   = wdata[2];
    end
    if (wr_scroll) begin
      if (!tog_q) begin
        t_nx[4:0] = wdata[7:3];
        fx_nx     = wdata[2:0];
      end else begin
        t_nx[14:12] = wdata[2:0];
        t_nx[9:5]   = wdata[7:3];
      end
      tog_nx = ~tog_q;
    end
    if (wr_addr) begin
      if (!tog_q) begin
        t_nx[14]   = 1'b0;
        t_nx[13:8] = wdata[5:0];
      end else begin
        t_nx[7:0] = wdata;
      end
      tog_nx = ~tog_q;
    end
    if (rd_status) tog_nx = 1'b0;
  end

  assign addr_copy = wr_addr & tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q      <= '0;
      fx_q     <= '0;
      tog_q    <= 1'b0;
      step32_q <= 1'b0;
    end else begin
      t_q      <= t_nx;
      fx_q     <= fx_nx;
      tog_q    <= tog_nx;
      step32_q <= step32_nx;
    end
  end
endmodule

// File: rtl/scroll_timing.sv
module scroll_timing #(
  parameter int DOT_W      = 9,
  parameter int LINE_W     = 9,
  parameter int VIS_LINES  = 240,
  parameter int PRE_LINE   = 261,
  parameter int X_FIRST    = 8,
  parameter int X_LAST     = 256,
  parameter int PREF_A     = 328,
  parameter int PREF_B     = 336,
  parameter int Y_DOT      = 256,
  parameter int HREL_DOT   = 257,
  parameter int VREL_FIRST = 280,
  parameter int VREL_LAST  = 304
) (
  input  logic              render_en,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              data_acc,
  output logic              ev_incx,
  output logic              ev_incy,
  output logic              ev_hrel,
  output logic              ev_vrel,
  output logic              ev_step
);
  localparam logic [LINE_W-1:0] L_VIS = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] L_PRE = LINE_W'(PRE_LINE);
  localparam logic [DOT_W-1:0]  D_XF  = DOT_W'(X_FIRST);
  localparam logic [DOT_W-1:0]  D_XL  = DOT_W'(X_LAST);
  localparam logic [DOT_W-1:0]  D_PA  = DOT_W'(PREF_A);
  localparam logic [DOT_W-1:0]  D_PB  = DOT_W'(PREF_B);
  localparam logic [DOT_W-1:0]  D_Y   = DOT_W'(Y_DOT);
  localparam logic [DOT_W-1:0]  D_H   = DOT_W'(HREL_DOT);
  localparam logic [DOT_W-1:0]  D_VF  = DOT_W'(VREL_FIRST);
  localparam logic [DOT_W-1:0]  D_VL  = DOT_W'(VREL_LAST);

  logic is_pre, active, x_dot;

  always_comb begin
    is_pre  = (line == L_PRE);
    active  = render_en && ((line < L_VIS) || is_pre);
    x_dot   = ((dot >= D_XF) && (dot <= D_XL) && (dot[2:0] == 3'd0)) ||
              (dot == D_PA) || (dot == D_PB);
    ev_incx = active && (x_dot || data_acc);
    ev_incy = active && ((dot == D_Y) || data_acc);
    ev_hrel = active && (dot == D_H);
    ev_vrel = active && is_pre && (dot >= D_VF) && (dot <= D_VL);
    ev_step = data_acc && !active;
  end
endmodule

// File: rtl/scroll_vpath.sv
module scroll_vpath
  import scroll_pkg::*;
#(
  parameter logic [7:0] EARLY_VAL = 8'h20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_incx,
  input  logic   ev_incy,
  input  logic   ev_hrel,
  input  logic   ev_vrel,
  input  logic   ev_step,
  input  logic   addr_copy,
  input  logic   step32,
  input  logic   early_hit,
  input  saddr_t t_q,
  input  saddr_t t_nx,
  output saddr_t v_q
);
  saddr_t v_inc, v_rel, t_src, v_nx;
  logic   any_inc, any_rel;

  always_comb begin
    v_inc = v_q;
    if (ev_incx) v_inc = step_cx(v_inc);
    if (ev_incy) v_inc = step_y(v_inc);
    if (ev_step) v_inc = v_q + (step32 ? 15'd32 : 15'd1);
    any_inc = ev_incx | ev_incy | ev_step;

    t_src = t_q;
    if (early_hit) t_src[10] = EARLY_VAL[0];

    v_rel = v_q;
    if (ev_hrel) begin
      v_rel[4:0] = t_src[4:0];
      v_rel[10]  = t_src[10];
    end
    if (ev_vrel) begin
      v_rel[14:11] = t_src[14:11];
      v_rel[9:5]   = t_src[9:5];
    end
    if (addr_copy) v_rel = t_nx;
    any_rel = ev_hrel | ev_vrel | addr_copy;

    if (any_inc && any_rel) v_nx = v_inc & v_rel;
    else if (any_rel)       v_nx = v_rel;
    else if (any_inc)       v_nx = v_inc;
    else                    v_nx = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_nx;
  end
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_pkg::*;
#(
  parameter int         DOT_W     = 9,
  parameter int         LINE_W    = 9,
  parameter int         VIS_LINES = 240,
  parameter int         PRE_LINE  = 261,
  parameter logic [7:0] EARLY_VAL = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              render_en,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              wr_ctrl,
  input  logic              wr_scroll,
  input  logic              wr_addr,
  input  logic              rd_status,
  input  logic [7:0]        wdata,
  input  logic              data_acc,
  input  logic              early_ctrl,
  output logic [14:0]       vaddr,
  output logic [14:0]       taddr,
  output logic [2:0]        fine_x,
  output logic              wtog
);
  logic   rst_s1, rst_s2;
  saddr_t t_q, t_nx, v_q;
  logic   step32, addr_copy;
  logic   ev_incx, ev_incy, ev_hrel, ev_vrel, ev_step, early_hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  scroll_tregs u_tregs (
    .clk(clk), .rst_n(rst_s2), .wr_ctrl(wr_ctrl), .wr_scroll(wr_scroll),
    .wr_addr(wr_addr), .rd_status(rd_status), .wdata(wdata),
    .t_q(t_q), .t_nx(t_nx), .fx_q(fine_x), .tog_q(wtog),
    .step32_q(step32), .addr_copy(addr_copy)
  );

  scroll_timing #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE)
  ) u_timing (
    .render_en(render_en), .line(line), .dot(dot), .data_acc(data_acc),
    .ev_incx(ev_incx), .ev_incy(ev_incy), .ev_hrel(ev_hrel),
    .ev_vrel(ev_vrel), .ev_step(ev_step)
  );

  assign early_hit = wr_ctrl & early_ctrl & ev_hrel;

  scroll_vpath #(.EARLY_VAL(EARLY_VAL)) u_vpath (
    .clk(clk), .rst_n(rst_s2), .ev_incx(ev_incx), .ev_incy(ev_incy),
    .ev_hrel(ev_hrel), .ev_vrel(ev_vrel), .ev_step(ev_step),
    .addr_copy(addr_copy), .step32(step32), .early_hit(early_hit),
    .t_q(t_q), .t_nx(t_nx), .v_q(v_q)
  );

  assign vaddr = v_q;
  assign taddr = t_q;
endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk #(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261
) (
  input logic              clk,
  input logic              rst_n,
  input logic              render_en,
  input logic [LINE_W-1:0] line,
  input logic [DOT_W-1:0]  dot,
  input logic              wr_ctrl,
  input logic              wr_scroll,
  input logic              wr_addr,
  input logic              rd_status,
  input logic [7:0]        wdata,
  input logic              data_acc,
  input logic [14:0]       vaddr,
  input logic [14:0]       taddr,
  input logic [2:0]        fine_x,
  input logic              wtog
);
  logic rline, at257;
  assign rline = render_en && ((line < LINE_W'(VIS_LINES)) || (line == LINE_W'(PRE_LINE)));
  assign at257 = rline && (dot == DOT_W'(257)) && !wr_addr && !wr_ctrl;

  p_status_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !wr_scroll && !wr_addr |=> !wtog);

  p_finex_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_scroll && !wtog && !rd_status |=> fine_x == $past(wdata[2:0]));

  p_addr_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr && wtog && !render_en && !data_acc |=> vaddr == taddr);

  p_hreload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at257 && !data_acc |=> (vaddr[4:0] == $past(taddr[4:0])) && (vaddr[10] == $past(taddr[10])));

  p_and_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    at257 && data_acc |=> (vaddr[4:0] & ~$past(taddr[4:0])) == 5'd0);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en && !data_acc && !(wr_addr && wtog) |=> $stable(vaddr));
endmodule

bind scroll_addr_unit scroll_addr_chk #(
  .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .render_en(render_en), .line(line), .dot(dot),
  .wr_ctrl(wr_ctrl), .wr_scroll(wr_scroll), .wr_addr(wr_addr),
  .rd_status(rd_status), .wdata(wdata), .data_acc(data_acc),
  .vaddr(vaddr), .taddr(taddr), .fine_x(fine_x), .wtog(wtog)
);

// File: tb/scroll_addr_unit_tb.sv
module scroll_addr_unit_tb;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  localparam logic [2:0] OP_NONE = 3'd0, OP_CTRL = 3'd1, OP_SCROLL = 3'd2,
                         OP_ADDR = 3'd3, OP_STAT = 3'd4;

  // {op, data, expected taddr, expected fine_x, expected toggle, expected vaddr}
  localparam logic [44:0] VEC [NVEC] = '{
    {OP_SCROLL, 8'hFD, 15'h001F, 3'd5, 1'b1, 15'h0000},
    {OP_SCROLL, 8'h5E, 15'h617F, 3'd5, 1'b0, 15'h0000},
    {OP_CTRL,   8'h03, 15'h6D7F, 3'd5, 1'b0, 15'h0000},
    {OP_ADDR,   8'hFF, 15'h3F7F, 3'd5, 1'b1, 15'h0000},
    {OP_STAT,   8'h00, 15'h3F7F, 3'd5, 1'b0, 15'h0000},
    {OP_ADDR,   8'h21, 15'h217F, 3'd5, 1'b1, 15'h0000},
    {OP_ADDR,   8'h08, 15'h2108, 3'd5, 1'b0, 15'h2108},
    {OP_CTRL,   8'h00, 15'h2108, 3'd5, 1'b0, 15'h2108}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic render_en, wr_ctrl, wr_scroll, wr_addr, rd_status, data_acc, early_ctrl;
  logic [8:0] line, dot;
  logic [7:0] wdata;
  logic [14:0] vaddr, taddr;
  logic [2:0] fine_x;
  logic wtog;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  scroll_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .line(line), .dot(dot),
    .wr_ctrl(wr_ctrl), .wr_scroll(wr_scroll), .wr_addr(wr_addr),
    .rd_status(rd_status), .wdata(wdata), .data_acc(data_acc),
    .early_ctrl(early_ctrl), .vaddr(vaddr), .taddr(taddr),
    .fine_x(fine_x), .wtog(wtog)
  );

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ren, input logic [8:0] ln, input logic [8:0] dt,
                     input logic [2:0] op, input logic [7:0] d,
                     input logic dacc, input logic early);
    @(negedge clk);
    render_en = ren; line = ln; dot = dt; wdata = d;
    wr_ctrl = (op == OP_CTRL); wr_scroll = (op == OP_SCROLL);
    wr_addr = (op == OP_ADDR); rd_status = (op == OP_STAT);
    data_acc = dacc; early_ctrl = early;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] op, input logic [7:0] d);
    cyc(1'b0, 9'd100, 9'd0, op, d, 1'b0, 1'b0);
  endtask

  // copy all of taddr into vaddr through the prerender reloads
  task automatic load_from_t();
    cyc(1'b1, 9'd261, 9'd257, OP_NONE, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 9'd261, 9'd280, OP_NONE, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; render_en = 0; line = 0; dot = 0; wdata = 0;
    wr_ctrl = 0; wr_scroll = 0; wr_addr = 0; rd_status = 0;
    data_acc = 0; early_ctrl = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 vaddr", vaddr, 15'h0);
    check("R1 taddr", taddr, 15'h0);
    check("R1 fine_x", {12'h0, fine_x}, 15'h0);
    check("R1 wtog", {14'h0, wtog}, 15'h0);

    // register write table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][44:42], VEC[i][41:34]);
      check("R2/R3/R5 taddr", taddr, VEC[i][33:19]);
      check("R2 fine_x", {12'h0, fine_x}, {12'h0, VEC[i][18:16]});
      check("R3/R4 wtog", {14'h0, wtog}, {14'h0, VEC[i][15]});
      check("R3 vaddr", vaddr, VEC[i][14:0]);
    end

    // R6 step across fields, then step 32 selected by control bit 2
    wr(OP_STAT, 8'h00);
    wr(OP_ADDR, 8'h3F); wr(OP_ADDR, 8'hFF);
    check("R3 vaddr copy", vaddr, 15'h3FFF);
    cyc(1'b0, 9'd100, 9'd0, OP_NONE, 8'h00, 1'b1, 1'b0);
    check("R6 step1 carry", vaddr, 15'h4000);
    wr(OP_CTRL, 8'h04);
    cyc(1'b0, 9'd100, 9'd0, OP_NONE, 8'h00, 1'b1, 1'b0);
    check("R5/R6 step32", vaddr, 15'h4020);

    // R13 dot events ignored with rendering off or on a blank line
    cyc(1'b0, 9'd10, 9'd8, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R13 render off", vaddr, 15'h4020);
    cyc(1'b1, 9'd245, 9'd257, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R13 blank line", vaddr, 15'h4020);

    // R7 coarse X wrap and prefetch dot
    wr(OP_CTRL, 8'h00);
    wr(OP_ADDR, 8'h00); wr(OP_ADDR, 8'h1F);
    cyc(1'b1, 9'd10, 9'd8, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R7 cx wrap", vaddr, 15'h0400);
    cyc(1'b1, 9'd10, 9'd9, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R7 idle dot", vaddr, 15'h0400);
    cyc(1'b1, 9'd10, 9'd328, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R7 dot328", vaddr, 15'h0401);

    // R8 / R9 / R10 coarse Y 29 wrap
    wr(OP_STAT, 8'h00);
    wr(OP_SCROLL, 8'h00); wr(OP_SCROLL, 8'hEF);
    check("R2 taddr", taddr, 15'h73A0);
    cyc(1'b1, 9'd261, 9'd257, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R9 hreload", vaddr, 15'h0000);
    cyc(1'b1, 9'd261, 9'd280, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R10 vreload", vaddr, 15'h73A0);
    cyc(1'b1, 9'd10, 9'd256, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R8 cy29 wrap", vaddr, 15'h0801);

    // R8 coarse Y 31 wraps without flip
    wr(OP_SCROLL, 8'h00); wr(OP_SCROLL, 8'hFF);
    load_from_t();
    check("R10 load", vaddr, 15'h73E0);
    cyc(1'b1, 9'd10, 9'd256, OP_NONE, 8'h00, 1'b0, 1'b0);
    check("R8 cy31 wrap", vaddr, 15'h0001);

    // R11 data access at dot 257: AND of increment and reload
    wr(OP_STAT, 8'h00);
    wr(OP_ADDR, 8'h00); wr(OP_ADDR, 8'h0E);
    wr(OP_SCROLL, 8'h98);
    wr(OP_CTRL, 8'h01);
    check("R5 taddr", taddr, 15'h0413);
    cyc(1'b1, 9'd10, 9'd257, OP_NONE, 8'h00, 1'b1, 1'b0);
    check("R11 acc vs reload", vaddr, 15'h0003);

    // R11 second address write on an increment dot
    wr(OP_STAT, 8'h00);
    wr(OP_ADDR, 8'h00);
    cyc(1'b1, 9'd10, 9'd8, OP_ADDR, 8'h35, 1'b0, 1'b0);
    check("R11 addr vs incx", vaddr, 15'h0004);
    check("R3 taddr", taddr, 15'h0035);

    // R12 early control value seen by the dot 257 reload
    wr(OP_CTRL, 8'h01);
    cyc(1'b1, 9'd10, 9'd257, OP_CTRL, 8'h01, 1'b0, 1'b1);
    check("R12 early nt", vaddr, 15'h0015);
    check("R12 taddr kept", taddr, 15'h0435);
    cyc(1'b1, 9'd10, 9'd257, OP_CTRL, 8'h01, 1'b0, 1'b0);
    check("R12 no early", vaddr, 15'h0415);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule